// File: doc/BRIEF.md
# ADC Conversion Sequencer Controller

This block walks an external analog-to-digital converter through a programmable run of conversion slots. Software sets an inclusive first and last slot index and a starting position in a sixteen-entry sample buffer, then sets the run bit. The controller presents one slot index at a time with a single-cycle request pulse. It waits for the converter's done strobe and stores the returned sample at the next buffer position.

A run is either a single pass, after which the run bit drops by itself, or continuous, in which case it loops from the first slot until software clears the run bit. A sticky data-available flag is raised at a cadence chosen in the control register: every sample, end of a single pass, every twelfth sample or every sixteenth sample. The flag, gated by an enable bit, drives an interrupt line. The control register also stores clock-select, reference, power and acquisition bits that are held for readback only.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset, both configuration readbacks are 0, the run bit, flag and interrupt are 0, no request is issued, and every buffer entry reads 0.
- R2: Register select 0 is the sequence register: buffer offset in bits 11:8, first slot in 6:4, last slot in 2:0. Select 1 is the control register: interval mode 11:10, clock select 9:8, reference enable 7, continuous 6, interrupt enable 5, power mode 4, acquisition 3:0. Select 2 is the command word: bit 0 run, bit 1 flag. Select 3 writes nothing. Bits 15:12, 7 and 3 of the sequence readback and bits 15:12 of the control readback are always 0.
- R3: Writes to the sequence and control registers are ignored while the run bit is 1.
- R4: A command write with bit 0 set while idle starts a run. Slots first through last are requested in order, one `conv_start` pulse each, with the slot on `conv_slot`. A single pass clears the run bit once the last slot's result is taken.
- R5: When the last index is below the first, the slot index counts up through 7, wraps to 0 and stops at the last index.
- R6: The first sample of a run goes to the buffer offset and each later sample goes to the next entry, wrapping modulo 16. `buf_rd_data` shows the entry selected by `buf_rd_idx`.
- R7: In continuous mode the run restarts at the first slot after the last one. A command write with bit 0 clear stops it at once, and a result still in flight is discarded.
- R8: Interval mode 0 sets the flag on every accepted sample.
- R9: Interval mode 1 sets the flag when a single pass takes its last sample, and never in continuous mode.
- R10: Interval modes 2 and 3 set the flag on every 12th and every 16th sample taken since the latest start; a new start restarts the count.
- R11: The flag stays set until a command write with bit 1 clear. A command write with bit 1 set leaves it unchanged. A flag set and a clear on the same edge leave the flag set.
- R12: `irq_o` is high exactly when the flag is set and the interrupt enable bit is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_sel | input | 2 | Register select (0 sequence, 1 control, 2 command) |
| reg_wr_data | input | 16 | Write data |
| seq_rdata | output | 16 | Sequence register readback |
| ctl_rdata | output | 16 | Control register readback |
| run_o | output | 1 | Run (conversion active) bit |
| flag_o | output | 1 | Sticky data-available flag |
| irq_o | output | 1 | Interrupt request |
| conv_start | output | 1 | One-cycle conversion request |
| conv_slot | output | 3 | Slot index of the current request |
| conv_done | input | 1 | Converter result strobe |
| conv_data | input | DATA_W | Converter result |
| buf_rd_idx | input | 4 | Sample buffer read index |
| buf_rd_data | output | DATA_W | Sample buffer read data |

## Verification
Two events can land on the same clock edge: the acceptance of a converter result, which may set the flag, and a software clear of that flag. The bench times a clear-command write so that it is sampled on the same edge as a done strobe. It expects the flag still set on the next cycle, and it checks that a clear placed between samples does drop the flag. A stop command racing an in-flight result is judged the same way: the stop lands while the request is outstanding, and the bench expects that result never to reach the buffer.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

   localparam int unsigned SLOT_BITS  = 3;
   localparam int unsigned BUFIX_BITS = 4;
   localparam int unsigned REG_W      = 16;

   localparam int unsigned CMD_RUN_BIT  = 0;
   localparam int unsigned CMD_FLAG_BIT = 1;

   localparam logic [1:0] RSEL_SEQ = 2'd0;
   localparam logic [1:0] RSEL_CTL = 2'd1;
   localparam logic [1:0] RSEL_CMD = 2'd2;

   typedef enum logic [1:0] {
      SQ_IDLE = 2'd0,
      SQ_REQ  = 2'd1,
      SQ_WAIT = 2'd2
   } sq_state_e;

   typedef enum logic [1:0] {
      IV_EACH    = 2'd0,
      IV_PASS    = 2'd1,
      IV_TWELVE  = 2'd2,
      IV_SIXTEEN = 2'd3
   } iv_mode_e;

   typedef struct packed {
      logic [BUFIX_BITS-1:0] base;
      logic [SLOT_BITS-1:0]  first;
      logic [SLOT_BITS-1:0]  last;
   } seq_cfg_t;

   typedef struct packed {
      iv_mode_e   ivl;
      logic [1:0] clk_sel;
      logic       ref_en;
      logic       cont;
      logic       irq_en;
      logic       pwr_mode;
      logic [3:0] acq;
   } ctl_cfg_t;

   function automatic logic [REG_W-1:0] seq_pack(seq_cfg_t c);
      return {4'b0000, c.base, 1'b0, c.first, 1'b0, c.last};
   endfunction

   function automatic seq_cfg_t seq_unpack(logic [REG_W-1:0] d);
      seq_cfg_t c;
      c.base  = d[11:8];
      c.first = d[6:4];
      c.last  = d[2:0];
      return c;
   endfunction

   function automatic logic [REG_W-1:0] ctl_pack(ctl_cfg_t c);
      return {4'b0000, c};
   endfunction

   function automatic ctl_cfg_t ctl_unpack(logic [REG_W-1:0] d);
      return ctl_cfg_t'(d[11:0]);
   endfunction

endpackage

// File: rtl/adc_seq_regs.sv
module adc_seq_regs
   import adc_seq_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [1:0]       wr_sel,
   input  logic [REG_W-1:0] wr_data,
   input  logic             locked,
   output seq_cfg_t         seq_cfg,
   output ctl_cfg_t         ctl_cfg,
   output logic [REG_W-1:0] seq_rd,
   output logic [REG_W-1:0] ctl_rd
);

   logic seq_we;
   logic ctl_we;
   logic unused_rsvd;

   assign seq_we = wr_en && !locked && (wr_sel == RSEL_SEQ);
   assign ctl_we = wr_en && !locked && (wr_sel == RSEL_CTL);

   // upper nibble is reserved in both registers
   assign unused_rsvd = ^wr_data[15:12];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         seq_cfg <= '0;
      end else if (seq_we) begin
         seq_cfg <= seq_unpack(wr_data);
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctl_cfg <= '0;
      end else if (ctl_we) begin
         ctl_cfg <= ctl_unpack(wr_data);
      end
   end

   assign seq_rd = seq_pack(seq_cfg);
   assign ctl_rd = ctl_pack(ctl_cfg);

endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
   import adc_seq_pkg::*;
#(
   parameter int unsigned SLOT_W = 3,
   parameter int unsigned IDX_W  = 4
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_cmd,
   input  logic              stop_cmd,
   input  logic [SLOT_W-1:0] cfg_first,
   input  logic [SLOT_W-1:0] cfg_last,
   input  logic [IDX_W-1:0]  cfg_base,
   input  logic              cont,
   input  logic              conv_done,
   output logic              busy,
   output logic              conv_start,
   output logic [SLOT_W-1:0] conv_slot,
   output logic              smp_acc,
   output logic              smp_last,
   output logic [IDX_W-1:0]  wr_idx
);

   sq_state_e         state;
   logic [SLOT_W-1:0] slot;
   logic [IDX_W-1:0]  idx;

   assign busy       = (state != SQ_IDLE);
   assign conv_start = (state == SQ_REQ);
   assign conv_slot  = slot;
   assign smp_acc    = (state == SQ_WAIT) && conv_done && !stop_cmd;
   assign smp_last   = (slot == cfg_last);
   assign wr_idx     = idx;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state <= SQ_IDLE;
         slot  <= '0;
         idx   <= '0;
      end else if (stop_cmd) begin
         state <= SQ_IDLE;
      end else if (start_cmd) begin
         state <= SQ_REQ;
         slot  <= cfg_first;
         idx   <= cfg_base;
      end else if (state == SQ_REQ) begin
         state <= SQ_WAIT;
      end else if (smp_acc) begin
         idx <= idx + IDX_W'(1);
         if (smp_last) begin
            if (cont) begin
               slot  <= cfg_first;
               state <= SQ_REQ;
            end else begin
               state <= SQ_IDLE;
            end
         end else begin
            slot  <= slot + SLOT_W'(1);
            state <= SQ_REQ;
         end
      end
   end

endmodule

// File: rtl/adc_seq_intr.sv
module adc_seq_intr
   import adc_seq_pkg::*;
#(
   parameter int unsigned INTV_A = 12,
   parameter int unsigned INTV_B = 16
)(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     restart,
   input  logic     smp_acc,
   input  logic     smp_last,
   input  iv_mode_e mode,
   input  logic     cont,
   input  logic     clr_cmd,
   input  logic     irq_en,
   output logic     flag,
   output logic     irq
);

   localparam int unsigned NUM_IV = 2;

   logic [NUM_IV-1:0] hit;
   logic              set_now;

   for (genvar g = 0; g < NUM_IV; g++) begin : g_iv
      localparam int unsigned LEN = (g == 0) ? INTV_A : INTV_B;
      localparam int unsigned CW  = $clog2(LEN);
      logic [CW-1:0] cnt;

      always_ff @(posedge clk) begin
         if (!rst_n || restart) begin
            cnt <= '0;
         end else if (smp_acc) begin
            cnt <= (cnt == CW'(LEN - 1)) ? '0 : cnt + CW'(1);
         end
      end

      assign hit[g] = smp_acc && (cnt == CW'(LEN - 1));
   end

   always_comb begin
      unique case (mode)
         IV_EACH:    set_now = smp_acc;
         IV_PASS:    set_now = smp_acc && smp_last && !cont;
         IV_TWELVE:  set_now = hit[0];
         IV_SIXTEEN: set_now = hit[1];
         default:    set_now = 1'b0;
      endcase
   end

   // a set on the same edge as a clear wins
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         flag <= 1'b0;
      end else if (set_now) begin
         flag <= 1'b1;
      end else if (clr_cmd) begin
         flag <= 1'b0;
      end
   end

   assign irq = flag && irq_en;

endmodule

// File: rtl/adc_seq_sbuf.sv
module adc_seq_sbuf #(
   parameter int unsigned DATA_W     = 12,
   parameter int unsigned IDX_W      = 4,
   parameter bit          KEEP_RESET = 1'b1
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic [DATA_W-1:0] rd_data
);

   localparam int unsigned DEPTH = 1 << IDX_W;

   logic [DATA_W-1:0] mem [DEPTH];

   if (KEEP_RESET) begin : g_rst
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
         end else if (we) begin
            mem[wr_idx] <= wr_data;
         end
      end
   end else begin : g_norst
      logic unused_rst;
      assign unused_rst = rst_n;
      always_ff @(posedge clk) begin
         if (we) mem[wr_idx] <= wr_data;
      end
   end

   assign rd_data = mem[rd_idx];

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
   import adc_seq_pkg::*;
#(
   parameter int unsigned DATA_W        = 12,
   parameter int unsigned SLOT_W        = 3,
   parameter int unsigned BUF_IDX_W     = 4,
   parameter int unsigned INTV_A        = 12,
   parameter int unsigned INTV_B        = 16,
   parameter bit          BUF_HAS_RESET = 1'b1
)(
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 reg_wr_en,
   input  logic [1:0]           reg_wr_sel,
   input  logic [15:0]          reg_wr_data,
   output logic [15:0]          seq_rdata,
   output logic [15:0]          ctl_rdata,
   output logic                 run_o,
   output logic                 flag_o,
   output logic                 irq_o,
   output logic                 conv_start,
   output logic [SLOT_W-1:0]    conv_slot,
   input  logic                 conv_done,
   input  logic [DATA_W-1:0]    conv_data,
   input  logic [BUF_IDX_W-1:0] buf_rd_idx,
   output logic [DATA_W-1:0]    buf_rd_data
);

   if (SLOT_W != SLOT_BITS) begin : g_bad_slot
      $error("SLOT_W must match the sequence register slot fields");
   end
   if (BUF_IDX_W != BUFIX_BITS) begin : g_bad_idx
      $error("BUF_IDX_W must match the sequence register offset field");
   end
   if (DATA_W < 1 || DATA_W > 16) begin : g_bad_dw
      $error("DATA_W must lie in 1..16");
   end
   if (INTV_A < 2 || INTV_B < 2) begin : g_bad_iv
      $error("interval lengths must be at least 2");
   end

   seq_cfg_t seq_cfg;
   ctl_cfg_t ctl_cfg;
   logic     cmd_wr;
   logic     start_cmd;
   logic     stop_cmd;
   logic     clr_cmd;
   logic     busy;
   logic     smp_acc;
   logic     smp_last;
   logic [BUF_IDX_W-1:0] wr_idx;

   assign cmd_wr    = reg_wr_en && (reg_wr_sel == RSEL_CMD);
   assign start_cmd = cmd_wr && reg_wr_data[CMD_RUN_BIT] && !busy;
   assign stop_cmd  = cmd_wr && !reg_wr_data[CMD_RUN_BIT] && busy;
   assign clr_cmd   = cmd_wr && !reg_wr_data[CMD_FLAG_BIT];

   adc_seq_regs u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (reg_wr_en),
      .wr_sel  (reg_wr_sel),
      .wr_data (reg_wr_data),
      .locked  (busy),
      .seq_cfg (seq_cfg),
      .ctl_cfg (ctl_cfg),
      .seq_rd  (seq_rdata),
      .ctl_rd  (ctl_rdata)
   );

   adc_seq_fsm #(
      .SLOT_W (SLOT_W),
      .IDX_W  (BUF_IDX_W)
   ) u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_cmd  (start_cmd),
      .stop_cmd   (stop_cmd),
      .cfg_first  (seq_cfg.first),
      .cfg_last   (seq_cfg.last),
      .cfg_base   (seq_cfg.base),
      .cont       (ctl_cfg.cont),
      .conv_done  (conv_done),
      .busy       (busy),
      .conv_start (conv_start),
      .conv_slot  (conv_slot),
      .smp_acc    (smp_acc),
      .smp_last   (smp_last),
      .wr_idx     (wr_idx)
   );

   adc_seq_intr #(
      .INTV_A (INTV_A),
      .INTV_B (INTV_B)
   ) u_intr (
      .clk      (clk),
      .rst_n    (rst_n),
      .restart  (start_cmd),
      .smp_acc  (smp_acc),
      .smp_last (smp_last),
      .mode     (ctl_cfg.ivl),
      .cont     (ctl_cfg.cont),
      .clr_cmd  (clr_cmd),
      .irq_en   (ctl_cfg.irq_en),
      .flag     (flag_o),
      .irq      (irq_o)
   );

   adc_seq_sbuf #(
      .DATA_W     (DATA_W),
      .IDX_W      (BUF_IDX_W),
      .KEEP_RESET (BUF_HAS_RESET)
   ) u_sbuf (
      .clk     (clk),
      .rst_n   (rst_n),
      .we      (smp_acc),
      .wr_idx  (wr_idx),
      .wr_data (conv_data),
      .rd_idx  (buf_rd_idx),
      .rd_data (buf_rd_data)
   );

   assign run_o = busy;

endmodule

// File: rtl/adc_seq_ctrl_chk.sv
module adc_seq_ctrl_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        cmd_sel,
   input logic        flag_keep,
   input logic [15:0] seq_rdata,
   input logic [15:0] ctl_rdata,
   input logic        run_o,
   input logic        flag_o,
   input logic        irq_o,
   input logic        conv_start,
   input logic [2:0]  conv_slot
);

   assert_reserved_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (seq_rdata[15:12] == 4'd0) && !seq_rdata[7] && !seq_rdata[3] && (ctl_rdata[15:12] == 4'd0));

   assert_cfg_locked_R3: assert property (@(posedge clk) disable iff (!rst_n)
      run_o |=> ($stable(seq_rdata) && $stable(ctl_rdata)));

   assert_start_first_slot_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(run_o) |-> (conv_start && (conv_slot == seq_rdata[6:4])));

   assert_single_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
      conv_start |=> !conv_start);

   assert_no_req_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !run_o |-> !conv_start);

   assert_flag_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_o && !(cmd_sel && !flag_keep)) |=> flag_o);

   assert_irq_needs_flag_R12: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> flag_o);

   assert_irq_masked_R12: assert property (@(posedge clk) disable iff (!rst_n)
      !ctl_rdata[5] |-> !irq_o);

endmodule

bind adc_seq_ctrl adc_seq_ctrl_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .cmd_sel    (reg_wr_en && (reg_wr_sel == 2'd2)),
   .flag_keep  (reg_wr_data[1]),
   .seq_rdata  (seq_rdata),
   .ctl_rdata  (ctl_rdata),
   .run_o      (run_o),
   .flag_o     (flag_o),
   .irq_o      (irq_o),
   .conv_start (conv_start),
   .conv_slot  (conv_slot)
);

// File: tb/adc_seq_ctrl_test.sv
module adc_seq_ctrl_test;

   localparam int DW = 12;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          reg_wr_en = 1'b0;
   logic [1:0]    reg_wr_sel = 2'd0;
   logic [15:0]   reg_wr_data = 16'd0;
   logic [15:0]   seq_rdata, ctl_rdata;
   logic          run_o, flag_o, irq_o, conv_start;
   logic [2:0]    conv_slot;
   logic          conv_done = 1'b0;
   logic [DW-1:0] conv_data = '0;
   logic [3:0]    buf_rd_idx = 4'd0;
   logic [DW-1:0] buf_rd_data;

   always #2 clk = ~clk;

   adc_seq_ctrl uut (
      .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_wr_sel(reg_wr_sel),
      .reg_wr_data(reg_wr_data), .seq_rdata(seq_rdata), .ctl_rdata(ctl_rdata),
      .run_o(run_o), .flag_o(flag_o), .irq_o(irq_o), .conv_start(conv_start),
      .conv_slot(conv_slot), .conv_done(conv_done), .conv_data(conv_data),
      .buf_rd_idx(buf_rd_idx), .buf_rd_data(buf_rd_data)
   );

   int vectors = 0;
   int miscompares = 0;
   bit finished = 1'b0;

   task automatic check(string req, string what, int act, int exp);
      vectors++;
      if (act != exp) begin
         miscompares++;
         $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
      end
   endtask

   // behavioural converter: latency 2 or 3 cycles, data = {0, slot, sample number}
   bit         m_busy = 1'b0;
   int         m_cnt = 0;
   logic [2:0] m_slot = 3'd0;
   int         nsamp = 0;

   always begin
      @(posedge clk);
      #1;
      if (!rst_n) begin
         conv_done = 1'b0;
         m_busy = 1'b0;
      end else begin
         if (conv_done) conv_done = 1'b0;
         if (m_busy) begin
            m_cnt--;
            if (m_cnt == 0) begin
               conv_done = 1'b1;
               conv_data = {1'b0, m_slot, nsamp[7:0]};
               nsamp++;
               m_busy = 1'b0;
            end
         end else if (conv_start) begin
            m_busy = 1'b1;
            m_cnt = 2 + (nsamp % 2);
            m_slot = conv_slot;
         end
      end
   end

   // scoreboard state
   int slot_q[$];
   int exp_buf[16];
   int exp_widx = 0;
   int exp_cnt = 0;
   bit exp_flag = 1'b0;
   int cur_slot = 0;
   int starts_seen = 0;

   initial for (int i = 0; i < 16; i++) exp_buf[i] = 0;

   // monitor: compare this cycle, then predict the effect of the coming edge
   always @(negedge clk) begin
      if (rst_n) begin
         bit cmd, acc, setf;
         int mode;
         check("R11", "flag", int'(flag_o), int'(exp_flag));
         check("R12", "irq", int'(irq_o), int'(exp_flag && ctl_rdata[5]));
         if (conv_start) begin
            starts_seen++;
            if (slot_q.size() == 0) begin
               check("R4", "unexpected request", 1, 0);
            end else begin
               int s;
               s = slot_q.pop_front();
               check("R4", "request slot", int'(conv_slot), s);
            end
            cur_slot = int'(conv_slot);
         end
         cmd  = reg_wr_en && (reg_wr_sel == 2'd2);
         mode = int'(ctl_rdata[11:10]);
         if (cmd && reg_wr_data[0] && !run_o) begin
            exp_cnt = 0;
            exp_widx = int'(seq_rdata[11:8]);
         end
         acc  = conv_done && run_o && !(cmd && !reg_wr_data[0]);
         setf = 1'b0;
         if (acc) begin
            exp_buf[exp_widx] = int'(conv_data);
            exp_widx = (exp_widx + 1) % 16;
            exp_cnt++;
            case (mode)
               0: setf = 1'b1;
               1: setf = !ctl_rdata[6] && (cur_slot == int'(seq_rdata[2:0]));
               2: setf = (exp_cnt % 12) == 0;
               default: setf = (exp_cnt % 16) == 0;
            endcase
         end
         if (cmd && !reg_wr_data[1]) exp_flag = 1'b0;
         if (setf) exp_flag = 1'b1;
      end
   end

   task automatic wr(input logic [1:0] sel, input logic [15:0] data);
      @(posedge clk);
      #1;
      reg_wr_en = 1'b1;
      reg_wr_sel = sel;
      reg_wr_data = data;
      @(posedge clk);
      #1;
      reg_wr_en = 1'b0;
   endtask

   function automatic int pass_len(int first, int last);
      return ((last - first + 8) % 8) + 1;
   endfunction

   task automatic push_slots(int first, int last, int count);
      int s;
      s = first;
      for (int k = 0; k < count; k++) begin
         slot_q.push_back(s);
         s = (s == last) ? first : (s + 1) % 8;
      end
   endtask

   task automatic wait_idle();
      int guard;
      guard = 0;
      do begin
         @(negedge clk);
         guard++;
      end while (run_o && guard < 2000);
      repeat (8) @(posedge clk);
      check("R4", "request queue drained", slot_q.size(), 0);
   endtask

   task automatic run_cont(int first, int last, int npass);
      int target;
      target = starts_seen + npass * pass_len(first, last) + 1;
      push_slots(first, last, npass * pass_len(first, last) + 1);
      wr(2'd2, 16'h0003);
      wait (starts_seen >= target);
      wr(2'd2, 16'h0002);
      check("R7", "run cleared by stop", int'(run_o), 0);
      repeat (8) @(posedge clk);
      check("R7", "request queue drained", slot_q.size(), 0);
   endtask

   task automatic check_buf(string req);
      for (int i = 0; i < 16; i++) begin
         @(posedge clk);
         #1;
         buf_rd_idx = 4'(i);
         @(negedge clk);
         check(req, $sformatf("buffer[%0d]", i), int'(buf_rd_data), exp_buf[i]);
      end
   endtask

   initial begin
      repeat (4) @(posedge clk);
      #1;
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      check("R1", "seq readback", int'(seq_rdata), 0);
      check("R1", "ctl readback", int'(ctl_rdata), 0);
      check("R1", "run", int'(run_o), 0);
      check("R1", "flag", int'(flag_o), 0);
      check("R1", "irq", int'(irq_o), 0);
      check("R1", "request", int'(conv_start), 0);
      check_buf("R1");

      // R2 layout and reserved bits
      wr(2'd0, 16'hF5AC);
      check("R2", "seq masked", int'(seq_rdata), 16'h0524);
      wr(2'd1, 16'hFFFF);
      check("R2", "ctl masked", int'(ctl_rdata), 16'h0FFF);
      wr(2'd3, 16'h0000);
      check("R2", "select 3 leaves seq", int'(seq_rdata), 16'h0524);
      check("R2", "select 3 leaves ctl", int'(ctl_rdata), 16'h0FFF);
      wr(2'd1, 16'hF020);
      check("R2", "ctl every-sample irq on", int'(ctl_rdata), 16'h0020);

      // R4 R6 R8 R12 single pass slots 2..4 into entries 5..7; R3 locked writes
      push_slots(2, 4, 3);
      wr(2'd2, 16'h0003);
      check("R4", "run set", int'(run_o), 1);
      wr(2'd0, 16'h0777);
      check("R3", "seq write ignored", int'(seq_rdata), 16'h0524);
      wr(2'd1, 16'h0000);
      check("R3", "ctl write ignored", int'(ctl_rdata), 16'h0020);
      wait_idle();
      check("R4", "single pass ends", int'(run_o), 0);
      check("R8", "flag after samples", int'(flag_o), 1);
      check("R12", "irq with enable", int'(irq_o), 1);
      check_buf("R6");

      // R11 write with flag bit set keeps flag, bit clear drops it
      wr(2'd2, 16'h0002);
      check("R11", "flag kept", int'(flag_o), 1);
      wr(2'd2, 16'h0000);
      check("R11", "flag cleared", int'(flag_o), 0);
      check("R12", "irq cleared", int'(irq_o), 0);

      // R5 R6 R9 wrapped slots 6,7,0,1 into entries 14,15,0,1, end-of-pass flag
      wr(2'd0, 16'h0E61);
      wr(2'd1, 16'h0420);
      push_slots(6, 1, 4);
      wr(2'd2, 16'h0003);
      wait_idle();
      check("R9", "flag at end of pass", int'(flag_o), 1);
      check_buf("R5");
      wr(2'd2, 16'h0000);

      // R7 R9 continuous with end-of-pass mode: flag never set
      wr(2'd0, 16'h0002);
      wr(2'd1, 16'h0460);
      run_cont(0, 2, 3);
      check("R9", "no flag in continuous", int'(flag_o), 0);
      check_buf("R7");

      // R10 every twelve, irq disabled
      wr(2'd0, 16'h0307);
      wr(2'd1, 16'h0840);
      run_cont(0, 7, 4);
      check("R10", "twelve-sample flag", int'(flag_o), 1);
      check("R12", "irq masked", int'(irq_o), 0);
      check_buf("R10");
      wr(2'd2, 16'h0000);

      // R11 set and clear on the same edge
      wr(2'd0, 16'h0003);
      wr(2'd1, 16'h0060);
      begin
         int target;
         target = starts_seen + 9;
         push_slots(0, 3, 9);
         wr(2'd2, 16'h0003);
         do begin
            @(posedge clk);
            #1.5;
         end while (!conv_done);
         reg_wr_en = 1'b1;
         reg_wr_sel = 2'd2;
         reg_wr_data = 16'h0001;
         @(posedge clk);
         #1;
         reg_wr_en = 1'b0;
         @(negedge clk);
         check("R11", "set wins over clear", int'(flag_o), 1);
         @(negedge clk);
         while (!conv_start) @(negedge clk);
         wr(2'd2, 16'h0001);
         @(negedge clk);
         check("R11", "clear between samples", int'(flag_o), 0);
         wait (starts_seen >= target);
         wr(2'd2, 16'h0002);
         repeat (8) @(posedge clk);
         check("R7", "queue drained", slot_q.size(), 0);
      end
      wr(2'd2, 16'h0000);

      // R10 sixteen-sample count restarts at each start
      wr(2'd0, 16'h0007);
      wr(2'd1, 16'h0C00);
      push_slots(0, 7, 8);
      wr(2'd2, 16'h0003);
      wait_idle();
      push_slots(0, 7, 8);
      wr(2'd2, 16'h0003);
      wait_idle();
      check("R10", "count restarted, no flag", int'(flag_o), 0);
      wr(2'd1, 16'h0C40);
      run_cont(0, 7, 2);
      check("R10", "sixteen-sample flag", int'(flag_o), 1);
      check_buf("R6");

      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

   initial begin
      #(4 * 150000);
      if (!finished) begin
         vectors++;
         miscompares++;
         $display("FAIL watchdog: run did not complete, actual 0 expected 1");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end

endmodule